// File: doc/BRIEF.md
# Flash Busy Status Read Logic

This block forms the word returned to a reader of a 16-bit parallel NOR-style flash model. While an embedded program or erase runs, it does not return array contents. It returns a status word instead. Bit 7 is a polling bit, and its meaning depends on the kind of operation. Bit 6 is a toggle bit that changes once for every read the block accepts. All other bits read as zero. When a program finishes, a settle window follows. In that window bit 7 already carries the true array bit, but the rest of the word still carries the status pattern. After the window, reads return plain array data. Command decoding, the storage array and real analog timing stay outside the block. All time is counted in clock cycles.

The command decoder pulses `op_start` and `op_done`. When it pulses `op_start`, it also gives the operation kind and the word being programmed. The array presents `array_rdata` for the address of the read in the same cycle as the request.

Reads use a valid/ready request and a valid/ready response.
- A request is accepted in a cycle where `rd_valid` and `rd_ready` are both high.
- `rd_ready` is high when the response register is empty or is being drained in that same cycle.
- The response appears one cycle after acceptance.
- The response stays unchanged until `rsp_ready` takes it.

Top module: `flash_busy_status`

## Requirements
- R1: After reset, `rsp_valid` is 0 and `rd_ready` is 1. The block is idle, and the toggle bit holds 0.
- R2: When idle, an accepted read returns `array_rdata` unchanged on `rsp_data`, in the cycle after acceptance.
- R3: During a program, bit 7 of each response is the inverse of bit 7 of the word latched at `op_start`. Later changes of `prog_word` have no effect.
- R4: During an erase, bit 7 of each response is 0.
- R5: During an operation, bit 6 starts at 0 after each accepted start. It inverts after every accepted read, so successive responses alternate 0,1,0,...
- R6: During an operation, every bit other than 7 and 6 reads as 0.
- R7: After `op_done` ends a program, the next SETTLE_CYC cycles form a settle window. In that window, bit 7 is the array bit 7 and bit 6 holds its last value without changing. All other bits are 0. After the window, R2 applies.
- R8: After `op_done` ends an erase, reads return array data from the next cycle on. An erased array therefore shows bit 7 as 1.
- R9: An `op_start` during an operation is ignored: the kind, the latched word and the toggle bit stay as they are. An `op_done` while idle is ignored.
- R10: `rd_ready` equals `!rsp_valid || rsp_ready`. A pending response holds its data while `rsp_ready` is low. The toggle bit advances only on accepted reads.
- R11: An `op_start` during the settle window starts a new operation at once and clears the toggle bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_start | input | 1 | Pulse: an embedded operation begins |
| op_done | input | 1 | Pulse: the embedded operation has finished |
| op_erase | input | 1 | Kind given with op_start: 1 erase, 0 program |
| prog_word | input | 16 | Word being programmed, taken at op_start |
| rd_valid | input | 1 | Read request valid |
| rd_ready | output | 1 | Read request accepted when high with rd_valid |
| array_rdata | input | 16 | Array contents at the read address |
| rsp_valid | output | 1 | Response word valid |
| rsp_ready | input | 1 | Response consumer ready |
| rsp_data | output | 16 | Response word |

## Verification
The hardest state to reach is the settle window interacting with other events. Examples are a new start arriving a few cycles into the window, or back-pressure stalling reads so that the toggle bit must not move while a response waits. The stimulus pulses `op_done` for a program and then issues a long read burst that spans the window edge. A start is also injected two cycles into the window. A third burst throttles `rsp_ready` in a repeating pattern during a busy phase, and the toggle sequence is checked against a behavioural model that is compared on every cycle.

// File: rtl/fbs_pkg.sv
package fbs_pkg;
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_BUSY   = 2'd1,
    PH_SETTLE = 2'd2
  } fbs_phase_e;
endpackage

// File: rtl/fbs_op_tracker.sv
module fbs_op_tracker
  import fbs_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int SETTLE_CYC = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_start,
  input  logic              op_done,
  input  logic              op_erase,
  input  logic [DATA_W-1:0] prog_word,
  output fbs_phase_e        phase,
  output logic              erase_q,
  output logic [DATA_W-1:0] word_q,
  output logic              start_take
);
  localparam bit HAS_SETTLE = (SETTLE_CYC > 0);
  localparam int CNT_W      = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1;
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(HAS_SETTLE ? SETTLE_CYC - 1 : 0);

  logic [CNT_W-1:0] cnt_q;

  // a start is honoured whenever no operation is running
  assign start_take = op_start && (phase != PH_BUSY);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= PH_IDLE;
      cnt_q   <= '0;
      erase_q <= 1'b0;
      word_q  <= '0;
    end else begin
      case (phase)
        PH_BUSY: begin
          if (op_done) begin
            if (erase_q || !HAS_SETTLE) begin
              phase <= PH_IDLE;
            end else begin
              phase <= PH_SETTLE;
              cnt_q <= CNT_LOAD;
            end
          end
        end
        PH_SETTLE: begin
          if (start_take) begin
            phase   <= PH_BUSY;
            erase_q <= op_erase;
            word_q  <= prog_word;
          end else if (cnt_q == '0) begin
            phase <= PH_IDLE;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        default: begin
          if (start_take) begin
            phase   <= PH_BUSY;
            erase_q <= op_erase;
            word_q  <= prog_word;
          end
        end
      endcase
    end
  end

  // R9: a done pulse with nothing running leaves the block idle
  assert_idle_stays_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_IDLE && !op_start) |=> (phase == PH_IDLE));

  // R9: the latched kind and word do not move while busy
  assert_busy_latch_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_BUSY) |=> ($stable(word_q) && $stable(erase_q)));

  // R8: an erase never passes through the settle window
  assert_erase_no_settle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_BUSY && erase_q) |=> (phase != PH_SETTLE));
endmodule

// File: rtl/fbs_toggle.sv
module fbs_toggle (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic adv,
  output logic tog_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   tog_q <= 1'b0;
    else if (clr) tog_q <= 1'b0;
    else if (adv) tog_q <= ~tog_q;
  end

  // R10: no accepted busy read, no movement
  assert_toggle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !adv) |=> $stable(tog_q));
endmodule

// File: rtl/fbs_word_mux.sv
module fbs_word_mux
  import fbs_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int POLL_BIT   = 7,
  parameter int TOGGLE_BIT = 6
) (
  input  fbs_phase_e        phase,
  input  logic              erase_q,
  input  logic [DATA_W-1:0] word_q,
  input  logic              tog_q,
  input  logic [DATA_W-1:0] array_rdata,
  output logic [DATA_W-1:0] word_out
);
  logic busy, settle;
  assign busy   = (phase == PH_BUSY);
  assign settle = (phase == PH_SETTLE);

  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    if (i == POLL_BIT) begin : g_poll
      assign word_out[i] = busy ? (!erase_q && !word_q[i]) : array_rdata[i];
    end else if (i == TOGGLE_BIT) begin : g_tog
      assign word_out[i] = (busy || settle) ? tog_q : array_rdata[i];
    end else begin : g_rest
      assign word_out[i] = (busy || settle) ? 1'b0 : array_rdata[i];
    end
  end
endmodule

// File: rtl/fbs_rsp_stage.sv
module fbs_rsp_stage #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (in_valid && in_ready) begin
      out_valid <= 1'b1;
      out_data  <= in_data;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // R10: a stalled response keeps its word
  assert_rsp_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
endmodule

// File: rtl/flash_busy_status.sv
module flash_busy_status
  import fbs_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int POLL_BIT   = 7,
  parameter int TOGGLE_BIT = 6,
  parameter int SETTLE_CYC = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_start,
  input  logic              op_done,
  input  logic              op_erase,
  input  logic [DATA_W-1:0] prog_word,
  input  logic              rd_valid,
  output logic              rd_ready,
  input  logic [DATA_W-1:0] array_rdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_data
);
  localparam logic [DATA_W-1:0] STATUS_MASK =
    (DATA_W'(1) << POLL_BIT) | (DATA_W'(1) << TOGGLE_BIT);

  fbs_phase_e        phase;
  logic              erase_q;
  logic [DATA_W-1:0] word_q;
  logic              start_take;
  logic              tog_q;
  logic              rd_fire;
  logic [DATA_W-1:0] word_next;

  assign rd_fire = rd_valid && rd_ready;

  fbs_op_tracker #(.DATA_W(DATA_W), .SETTLE_CYC(SETTLE_CYC)) u_track (
    .clk(clk), .rst_n(rst_n), .op_start(op_start), .op_done(op_done),
    .op_erase(op_erase), .prog_word(prog_word), .phase(phase),
    .erase_q(erase_q), .word_q(word_q), .start_take(start_take)
  );

  fbs_toggle u_tog (
    .clk(clk), .rst_n(rst_n), .clr(start_take),
    .adv(rd_fire && (phase == PH_BUSY)), .tog_q(tog_q)
  );

  fbs_word_mux #(.DATA_W(DATA_W), .POLL_BIT(POLL_BIT), .TOGGLE_BIT(TOGGLE_BIT)) u_mux (
    .phase(phase), .erase_q(erase_q), .word_q(word_q), .tog_q(tog_q),
    .array_rdata(array_rdata), .word_out(word_next)
  );

  fbs_rsp_stage #(.DATA_W(DATA_W)) u_rsp (
    .clk(clk), .rst_n(rst_n), .in_valid(rd_valid), .in_ready(rd_ready),
    .in_data(word_next), .out_valid(rsp_valid), .out_ready(rsp_ready),
    .out_data(rsp_data)
  );

  // R4: erase polling bit reads low
  assert_erase_poll_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_fire && phase == PH_BUSY && erase_q) |=> (rsp_data[POLL_BIT] == 1'b0));

  // R3: program polling bit is the inverse of the latched word
  assert_prog_poll_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_fire && phase == PH_BUSY && !erase_q) |=> (rsp_data[POLL_BIT] != word_q[POLL_BIT]));

  // R6: non-status bits are zero while busy
  assert_busy_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_fire && phase == PH_BUSY) |=> ((rsp_data & ~STATUS_MASK) == '0));

  // R5: an accepted start clears the toggle bit
  assert_toggle_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    start_take |=> (tog_q == 1'b0));
endmodule

// File: tb/tb_flash_busy_status.sv
`timescale 1ns/1ps
module tb_flash_busy_status;
  localparam int SETTLE = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic op_start = 0, op_done = 0, op_erase = 0;
  logic [15:0] prog_word = '0;
  logic rd_valid = 0, rsp_ready = 1;
  logic [15:0] array_rdata = '0;
  logic rd_ready, rsp_valid;
  logic [15:0] rsp_data;

  int total = 0, bad = 0;
  string cur_req = "R1";

  always #2 clk = ~clk;

  flash_busy_status #(.SETTLE_CYC(SETTLE)) dut (
    .clk(clk), .rst_n(rst_n), .op_start(op_start), .op_done(op_done),
    .op_erase(op_erase), .prog_word(prog_word), .rd_valid(rd_valid),
    .rd_ready(rd_ready), .array_rdata(array_rdata), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_data(rsp_data)
  );

  // behavioural reference: 0 idle, 1 busy, 2 settle
  int m_st, m_cnt;
  bit m_tog, m_er, m_ev;
  logic [15:0] m_pw, m_ed;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_cnt = 0; m_tog = 0; m_er = 0; m_ev = 0; m_pw = '0; m_ed = '0;
    end else begin
      bit fire;
      fire = rd_valid && (!m_ev || rsp_ready);
      if (fire) begin
        if (m_st == 1) begin
          m_ed = '0;
          m_ed[7] = m_er ? 1'b0 : ~m_pw[7];
          m_ed[6] = m_tog;
          m_tog = ~m_tog;
        end else if (m_st == 2) begin
          m_ed = '0;
          m_ed[7] = array_rdata[7];
          m_ed[6] = m_tog;
        end else begin
          m_ed = array_rdata;
        end
        m_ev = 1;
      end else if (rsp_ready) begin
        m_ev = 0;
      end
      if (m_st != 1 && op_start) begin
        m_st = 1; m_er = op_erase; m_pw = prog_word; m_tog = 0;
      end else if (m_st == 1) begin
        if (op_done) begin
          if (m_er) m_st = 0;
          else begin m_st = 2; m_cnt = SETTLE - 1; end
        end
      end else if (m_st == 2) begin
        if (m_cnt == 0) m_st = 0;
        else m_cnt = m_cnt - 1;
      end
    end
  end

  task automatic chk(bit ok, string what, logic [15:0] act, logic [15:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h", cur_req, what, act, exp);
    end
  endtask

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      chk(rd_ready == (!m_ev || rsp_ready), "rd_ready", {15'd0, rd_ready},
          {15'd0, (!m_ev || rsp_ready)});
      chk(rsp_valid == m_ev, "rsp_valid", {15'd0, rsp_valid}, {15'd0, m_ev});
      if (m_ev) chk(rsp_data === m_ed, "rsp_data", rsp_data, m_ed);
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic rd_burst(int n, bit bp);
    for (int i = 0; i < n; i++) begin
      rd_valid = 1;
      rsp_ready = bp ? ((i % 3) != 0) : 1'b1;
      array_rdata = 16'($urandom);
      step();
    end
    rd_valid = 0; rsp_ready = 1;
    step();
  endtask

  task automatic pulse_start(bit e, logic [15:0] w);
    op_start = 1; op_erase = e; prog_word = w;
    step();
    op_start = 0; prog_word = ~w; op_erase = ~e;
  endtask

  task automatic pulse_done();
    op_done = 1; step(); op_done = 0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    // R1: reset state
    chk(rsp_valid == 0, "reset rsp_valid", {15'd0, rsp_valid}, 16'd0);
    chk(rd_ready == 1, "reset rd_ready", {15'd0, rd_ready}, 16'd1);
    step();
    cur_req = "R2"; rd_burst(6, 0); rd_burst(6, 1);
    cur_req = "R3/R5/R6"; pulse_start(0, 16'h00A5); rd_burst(5, 0);
    cur_req = "R10"; rd_burst(9, 1);
    cur_req = "R7"; pulse_done(); rd_burst(SETTLE + 4, 0);
    cur_req = "R4"; pulse_start(1, 16'h0000); rd_burst(5, 0);
    cur_req = "R8"; pulse_done(); array_rdata = 16'hFFFF; rd_burst(4, 0);
    cur_req = "R3"; pulse_start(0, 16'h1234); rd_burst(4, 0);
    cur_req = "R9"; pulse_start(1, 16'h5A5A); rd_burst(3, 0);
    pulse_done(); rd_burst(SETTLE + 2, 0);
    pulse_done(); rd_burst(3, 0);
    cur_req = "R11"; pulse_start(0, 16'h0080); rd_burst(2, 0);
    pulse_done(); step(); step();
    pulse_start(1, 16'h0000); rd_burst(4, 1);
    pulse_done(); rd_burst(3, 0);
    repeat (3) step();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule